// File: doc/BRIEF.md
# Two-Stage Expiry Watchdog Timer

The block is a countdown watchdog meant for a chipset's power-management domain. Software programs a reload count and then periodically "kicks" the timer. While the timer runs, it decrements once per `tick_i` pulse. When it reaches zero, it reloads itself and counts again. The first expiry does not reset the system. It latches a timeout flag in the status register, and if both the watchdog SMI enable and the global SMI enable are set, it raises a level system-management interrupt request. The interrupt handler is expected to clear the flag (write-one-to-clear) and kick the timer. If the flag is still set when the timer expires a second time, the block raises a sticky reboot request.

Control is handled by a small state machine with three states:
- **HALT**: the counter is frozen. This is the state after reset.
- **RUN**: the counter decrements on each tick.
- **REBOOT**: terminal until reset, with the counter stopped.

Its transitions are:
- **HALT→RUN** when the halt bit is cleared.
- **RUN→HALT** when the halt bit is set.
- **RUN→REBOOT** on an expiry with the flag already set.
- **REBOOT→REBOOT** otherwise.

An expiry in RUN with the flag clear keeps the state and sets the flag. Registers are reached through a single-cycle write port and a combinational read port.

Because the count resolution is one tick, a reload value of N gives a first expiry N+1 ticks after a kick. The hang time before reboot therefore lies between N+1 and 2(N+1) ticks, depending on when the hang began.

Top module: `wdt_two_stage`

## Requirements
- R1: With reload value N, the first expiry occurs on the (N+1)th tick counted in RUN after a kick. The counter reloads to N by itself at each expiry and keeps counting.
- R2: An expiry with the timeout flag clear sets the flag (status register, address 1, bit 3) and does not assert `reboot_o`.
- R3: An expiry with the flag already set asserts `reboot_o`. It stays high until reset, and the counter stops.
- R4: Writing 1 to status bit 3 clears the flag, and writing 0 leaves it unchanged. An expiry in the same cycle as a clearing write leaves the flag set.
- R5: `smi_o` is high exactly while the flag is set, bit 13 of the SMI enable register (address 0) is 1, and bit 0 of that register (the global enable) is 1.
- R6: Control register (address 2) bit 11 set freezes the counter, and ticks have no effect. Clearing the bit resumes counting from the frozen value.
- R7: Writing 1 to control bit 0 reloads the counter from the reload register (address 3), in any state. It wins over a same-cycle expiry, so no expiry happens in that cycle.
- R8: After reset, the halt bit is 1, the flag is 0, the SMI enable register is 0, the reload register holds `RELOAD_RST`, and `smi_o` and `reboot_o` are 0.
- R9: Readback returns the following:
  - Address 0: the SMI enable word as written.
  - Address 1: only bit 3.
  - Address 2: the written word with bit 0 reading 0.
  - Address 3: the reload value in the low `CNT_W` bits, with zeros above.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| tick_i | input | 1 | Count-rate pulse, one decrement per high cycle in RUN |
| reg_wr_i | input | 1 | Register write strobe |
| reg_addr_i | input | 2 | Register address (0 SMI enable, 1 status, 2 control, 3 reload) |
| reg_wdata_i | input | DW | Write data |
| reg_rdata_o | output | DW | Combinational read data for `reg_addr_i` |
| smi_o | output | 1 | System-management interrupt request level |
| reboot_o | output | 1 | Sticky reboot request |

## Verification
Each kind of internal fault shows up at the ports within a predictable number of ticks:
- **Wrong counter value**: the flag appears on the wrong tick, which is visible at status bit 3 one cycle after that tick. A sweep over small reload values exposes off-by-one loads and missed automatic reloads within N+1 ticks.
- **Wrong FSM state**: a state stuck in HALT shows as a flag that never sets. A premature REBOOT shows as `reboot_o` high after a single expiry. A lost REBOOT shows as `reboot_o` low one cycle after the second uncleared expiry.
- **Faulty enable gating or W1C priority**: this changes `smi_o` or status readback in the cycle right after the write.

// File: rtl/wdt_pkg.sv
package wdt_pkg;
    typedef enum logic [1:0] {
        ST_HALT   = 2'd0,
        ST_RUN    = 2'd1,
        ST_REBOOT = 2'd2
    } wdt_state_e;

    localparam logic [1:0] A_SMI_EN = 2'd0;
    localparam logic [1:0] A_STATUS = 2'd1;
    localparam logic [1:0] A_CTRL   = 2'd2;
    localparam logic [1:0] A_RELOAD = 2'd3;

    localparam int B_FLAG     = 3;
    localparam int B_SMI_WDT  = 13;
    localparam int B_SMI_GLB  = 0;
    localparam int B_HALT     = 11;
    localparam int B_KICK     = 0;
endpackage

// File: rtl/wdt_regs.sv
module wdt_regs
    import wdt_pkg::*;
#(
    parameter int DW = 16,
    parameter int CNT_W = 8,
    parameter logic [CNT_W-1:0] RELOAD_RST = CNT_W'(20)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_i,
    input  logic [1:0]       addr_i,
    input  logic [DW-1:0]    wdata_i,
    input  logic             set_flag_i,
    output logic [DW-1:0]    rdata_o,
    output logic [DW-1:0]    smi_en_o,
    output logic             flag_o,
    output logic             halt_o,
    output logic             kick_o,
    output logic [CNT_W-1:0] reload_o
);
    localparam int PAD_W = DW - CNT_W;
    localparam logic [DW-1:0] CTRL_RST = DW'(1) << B_HALT;

    logic [DW-1:0]    smi_en_q;
    logic [DW-1:0]    ctrl_q;
    logic             flag_q;
    logic [CNT_W-1:0] reload_q;
    logic             wr_smi, wr_sts, wr_ctl, wr_rld;

    assign wr_smi = wr_i && (addr_i == A_SMI_EN);
    assign wr_sts = wr_i && (addr_i == A_STATUS);
    assign wr_ctl = wr_i && (addr_i == A_CTRL);
    assign wr_rld = wr_i && (addr_i == A_RELOAD);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            smi_en_q <= '0;
            ctrl_q   <= CTRL_RST;
            reload_q <= RELOAD_RST;
        end else begin
            if (wr_smi) smi_en_q <= wdata_i;
            if (wr_ctl) ctrl_q   <= wdata_i & ~(DW'(1) << B_KICK);
            if (wr_rld) reload_q <= wdata_i[CNT_W-1:0];
        end
    end

    // expiry set takes priority over a write-one clear
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                        flag_q <= 1'b0;
        else if (set_flag_i)               flag_q <= 1'b1;
        else if (wr_sts && wdata_i[B_FLAG]) flag_q <= 1'b0;
    end

    always_comb begin
        rdata_o = '0;
        unique case (addr_i)
            A_SMI_EN: rdata_o = smi_en_q;
            A_STATUS: rdata_o[B_FLAG] = flag_q;
            A_CTRL:   rdata_o = ctrl_q;
            A_RELOAD: rdata_o = {{PAD_W{1'b0}}, reload_q};
            default:  rdata_o = '0;
        endcase
    end

    assign smi_en_o = smi_en_q;
    assign flag_o   = flag_q;
    assign halt_o   = ctrl_q[B_HALT];
    assign kick_o   = wr_ctl && wdata_i[B_KICK];
    assign reload_o = reload_q;
endmodule

// File: rtl/wdt_counter.sv
module wdt_counter #(
    parameter int CNT_W = 8,
    parameter logic [CNT_W-1:0] RELOAD_RST = CNT_W'(20)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run_i,
    input  logic             tick_i,
    input  logic             kick_i,
    input  logic [CNT_W-1:0] reload_i,
    output logic [CNT_W-1:0] cnt_o,
    output logic             expire_o
);
    logic [CNT_W-1:0] cnt_q;

    assign expire_o = run_i && tick_i && !kick_i && (cnt_q == '0);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                cnt_q <= RELOAD_RST;
        else if (kick_i || expire_o) cnt_q <= reload_i;
        else if (run_i && tick_i)  cnt_q <= cnt_q - CNT_W'(1);
    end

    assign cnt_o = cnt_q;
endmodule

// File: rtl/wdt_fsm.sv
module wdt_fsm
    import wdt_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       halt_i,
    input  logic       expire_i,
    input  logic       flag_i,
    output wdt_state_e state_o,
    output logic       run_o,
    output logic       set_flag_o,
    output logic       reboot_o
);
    wdt_state_e state_q, state_d;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_HALT;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_HALT:   if (!halt_i) state_d = ST_RUN;
            ST_RUN: begin
                if (expire_i && flag_i) state_d = ST_REBOOT;
                else if (halt_i)        state_d = ST_HALT;
            end
            ST_REBOOT: state_d = ST_REBOOT;
            default:   state_d = ST_HALT;
        endcase
    end

    always_comb begin
        run_o      = 1'b0;
        set_flag_o = 1'b0;
        reboot_o   = 1'b0;
        unique case (state_q)
            ST_HALT:   ;
            ST_RUN: begin
                run_o      = 1'b1;
                set_flag_o = expire_i && !flag_i;
            end
            ST_REBOOT: reboot_o = 1'b1;
            default:   ;
        endcase
    end

    assign state_o = state_q;
endmodule

// File: rtl/wdt_two_stage.sv
module wdt_two_stage
    import wdt_pkg::*;
#(
    parameter int DW = 16,
    parameter int CNT_W = 8,
    parameter logic [CNT_W-1:0] RELOAD_RST = CNT_W'(20)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          tick_i,
    input  logic          reg_wr_i,
    input  logic [1:0]    reg_addr_i,
    input  logic [DW-1:0] reg_wdata_i,
    output logic [DW-1:0] reg_rdata_o,
    output logic          smi_o,
    output logic          reboot_o
);
    logic [DW-1:0]    smi_en;
    logic             flag, halt, kick, run, set_flag, expire;
    logic [CNT_W-1:0] reload, cnt;
    wdt_state_e       state;

    wdt_regs #(.DW(DW), .CNT_W(CNT_W), .RELOAD_RST(RELOAD_RST)) u_regs (
        .clk(clk), .rst_n(rst_n), .wr_i(reg_wr_i), .addr_i(reg_addr_i),
        .wdata_i(reg_wdata_i), .set_flag_i(set_flag), .rdata_o(reg_rdata_o),
        .smi_en_o(smi_en), .flag_o(flag), .halt_o(halt), .kick_o(kick),
        .reload_o(reload)
    );

    wdt_counter #(.CNT_W(CNT_W), .RELOAD_RST(RELOAD_RST)) u_cnt (
        .clk(clk), .rst_n(rst_n), .run_i(run), .tick_i(tick_i),
        .kick_i(kick), .reload_i(reload), .cnt_o(cnt), .expire_o(expire)
    );

    wdt_fsm u_fsm (
        .clk(clk), .rst_n(rst_n), .halt_i(halt), .expire_i(expire),
        .flag_i(flag), .state_o(state), .run_o(run),
        .set_flag_o(set_flag), .reboot_o(reboot_o)
    );

    assign smi_o = flag && smi_en[B_SMI_WDT] && smi_en[B_SMI_GLB];
endmodule

// File: rtl/wdt_two_stage_chk.sv
module wdt_two_stage_chk
    import wdt_pkg::*;
#(
    parameter int DW = 16,
    parameter int CNT_W = 8
) (
    input logic             clk,
    input logic             rst_n,
    input logic             reg_wr_i,
    input logic [1:0]       reg_addr_i,
    input logic [DW-1:0]    reg_wdata_i,
    input logic             smi_o,
    input logic             reboot_o,
    input logic             flag,
    input logic             kick,
    input logic             run,
    input logic [DW-1:0]    smi_en,
    input logic [CNT_W-1:0] cnt
);
    p_reboot_sticky_r3: assert property (@(posedge clk) disable iff (!rst_n)
        reboot_o |=> reboot_o);

    p_reboot_needs_flag_r3: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(reboot_o) |-> $past(flag));

    p_flag_clear_by_write_r4: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(flag) |-> $past(reg_wr_i && reg_addr_i == A_STATUS && reg_wdata_i[B_FLAG]));

    p_smi_needs_global_r5: assert property (@(posedge clk) disable iff (!rst_n)
        !smi_en[B_SMI_GLB] |-> !smi_o);

    p_smi_needs_flag_r5: assert property (@(posedge clk) disable iff (!rst_n)
        !flag |-> !smi_o);

    p_frozen_when_idle_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (!run && !kick) |=> $stable(cnt));
endmodule

bind wdt_two_stage wdt_two_stage_chk #(.DW(DW), .CNT_W(CNT_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .reg_wr_i(reg_wr_i), .reg_addr_i(reg_addr_i),
    .reg_wdata_i(reg_wdata_i), .smi_o(smi_o), .reboot_o(reboot_o),
    .flag(flag), .kick(kick), .run(run), .smi_en(smi_en), .cnt(cnt)
);

// File: tb/wdt_two_stage_tb.sv
module wdt_two_stage_tb;
    localparam int DW = 16;
    localparam int CNT_W = 8;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          tick = 1'b0;
    logic          wr = 1'b0;
    logic [1:0]    addr = 2'd0;
    logic [DW-1:0] wdata = '0;
    logic [DW-1:0] rdata;
    logic          smi, reboot;
    int total = 0;
    int bad = 0;

    always #2 clk = ~clk;

    wdt_two_stage #(.DW(DW), .CNT_W(CNT_W), .RELOAD_RST(8'd20)) u_dut (
        .clk(clk), .rst_n(rst_n), .tick_i(tick), .reg_wr_i(wr),
        .reg_addr_i(addr), .reg_wdata_i(wdata), .reg_rdata_o(rdata),
        .smi_o(smi), .reboot_o(reboot)
    );

    task automatic chk(input string req, input logic [DW-1:0] act, input logic [DW-1:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic do_reset();
        @(negedge clk); rst_n = 1'b0; wr = 1'b0; tick = 1'b0;
        @(negedge clk); @(negedge clk); rst_n = 1'b1;
        @(negedge clk);
    endtask

    task automatic wreg(input logic [1:0] a, input logic [DW-1:0] d);
        @(negedge clk); wr = 1'b1; addr = a; wdata = d;
        @(negedge clk); wr = 1'b0;
    endtask

    task automatic rreg(input logic [1:0] a, output logic [DW-1:0] d);
        @(negedge clk); addr = a; #1 d = rdata;
    endtask

    task automatic ticks(input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk); tick = 1'b1;
            @(negedge clk); tick = 1'b0;
        end
    endtask

    function automatic logic [DW-1:0] fl(input logic f);
        return f ? 16'h0008 : 16'h0000;
    endfunction

    // halt, load N, kick, clear flag, resume
    task automatic start(input int n);
        wreg(2'd2, 16'h0800);
        wreg(2'd3, DW'(n));
        wreg(2'd2, 16'h0801);
        wreg(2'd1, 16'h0008);
        wreg(2'd2, 16'h0000);
        @(negedge clk);
    endtask

    initial begin
        for (int c = 0; c < 150000; c++) @(posedge clk);
        bad++; total++;
        $display("FAIL watchdog expired actual=hung expected=done");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        logic [DW-1:0] r;
        do_reset();
        // R8 reset state
        rreg(2'd0, r); chk("R8 smi_en", r, 16'h0000);
        rreg(2'd1, r); chk("R8 flag", r, 16'h0000);
        rreg(2'd2, r); chk("R8 halt", r, 16'h0800);
        rreg(2'd3, r); chk("R8 reload", r, 16'd20);
        chk("R8 smi", {15'd0, smi}, 16'd0);
        chk("R8 reboot", {15'd0, reboot}, 16'd0);
        ticks(30);
        rreg(2'd1, r); chk("R8/R6 halted after reset", r, 16'h0000);

        // R9 readback
        wreg(2'd0, 16'hA5C3); rreg(2'd0, r); chk("R9 smi_en rb", r, 16'hA5C3);
        wreg(2'd2, 16'h0F0F); rreg(2'd2, r); chk("R9 ctrl rb kick bit 0", r, 16'h0F0E);
        wreg(2'd3, 16'hFF37); rreg(2'd3, r); chk("R9 reload rb", r, 16'h0037);
        wreg(2'd1, 16'hFFFF); rreg(2'd1, r); chk("R9 status rb", r, 16'h0000);

        // R1 R2 R3 sweep over reload values
        for (int n = 0; n < 6; n++) begin
            do_reset();
            start(n);
            ticks(n);
            rreg(2'd1, r); chk("R1 no early expiry", r, fl(0));
            ticks(1);
            rreg(2'd1, r); chk("R1 R2 first expiry flag", r, fl(1));
            chk("R2 no reboot", {15'd0, reboot}, 16'd0);
            wreg(2'd1, 16'h0008);
            rreg(2'd1, r); chk("R4 w1c", r, fl(0));
            ticks(n);
            rreg(2'd1, r); chk("R1 auto reload early", r, fl(0));
            ticks(1);
            rreg(2'd1, r); chk("R1 auto reload expiry", r, fl(1));
            chk("R2 no reboot 2", {15'd0, reboot}, 16'd0);
            ticks(n);
            chk("R3 not yet", {15'd0, reboot}, 16'd0);
            ticks(1);
            chk("R3 reboot", {15'd0, reboot}, 16'd1);
            ticks(3);
            chk("R3 sticky", {15'd0, reboot}, 16'd1);
            wreg(2'd1, 16'h0008);
            ticks(2);
            chk("R3 sticky after clear", {15'd0, reboot}, 16'd1);
        end

        // R4 write 0 keeps flag, set wins over clear
        do_reset();
        start(0);
        ticks(1);
        wreg(2'd1, 16'hFFF7);
        rreg(2'd1, r); chk("R4 write0 keeps", r, fl(1));
        wreg(2'd1, 16'h0008);
        @(negedge clk); tick = 1'b1; wr = 1'b1; addr = 2'd1; wdata = 16'h0008;
        @(negedge clk); tick = 1'b0; wr = 1'b0;
        rreg(2'd1, r); chk("R4 set wins", r, fl(1));
        chk("R4 no reboot", {15'd0, reboot}, 16'd0);

        // R5 SMI gating sweep
        for (int f = 0; f < 2; f++) begin
            do_reset();
            if (f == 1) begin start(0); ticks(1); wreg(2'd2, 16'h0800); end
            for (int e = 0; e < 4; e++) begin
                wreg(2'd0, {2'b00, e[1], 12'd0, e[0]});
                @(negedge clk);
                chk("R5 smi", {15'd0, smi}, {15'd0, (f == 1) && (e == 3)});
            end
        end

        // R6 halt freezes and resumes
        do_reset();
        start(4);
        ticks(2);
        wreg(2'd2, 16'h0800);
        @(negedge clk);
        ticks(10);
        rreg(2'd1, r); chk("R6 frozen", r, fl(0));
        wreg(2'd2, 16'h0000);
        @(negedge clk);
        ticks(2);
        rreg(2'd1, r); chk("R6 resume no early", r, fl(0));
        ticks(1);
        rreg(2'd1, r); chk("R6 resume expiry", r, fl(1));

        // R7 keepalive reload and priority
        do_reset();
        start(3);
        ticks(3);
        wreg(2'd2, 16'h0001);
        ticks(3);
        rreg(2'd1, r); chk("R7 kick reload", r, fl(0));
        @(negedge clk); tick = 1'b1; wr = 1'b1; addr = 2'd2; wdata = 16'h0001;
        @(negedge clk); tick = 1'b0; wr = 1'b0;
        rreg(2'd1, r); chk("R7 kick wins", r, fl(0));
        ticks(3);
        rreg(2'd1, r); chk("R7 after kick", r, fl(0));
        ticks(1);
        rreg(2'd1, r); chk("R7 expiry after kick", r, fl(1));

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule